// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked single-port RAM with a cache-style burst interface. Each rising clock edge is decoded into one of four kinds of cycle: a deselect, the start of a burst at an external address, a continuing burst step, or a suspended burst that holds the current address. Two active-low address strobes can start a burst. The processor-side strobe always reads and is gated by the primary enable. The controller-side strobe reads or writes, depending on the write inputs at that edge.

Inside an open burst, the two low address bits come from a 2-bit counter, so a burst covers four words and then wraps. The default order is interleaved: the counter is XORed into the low bits of the start address. A parameter selects linear order instead. Writes commit on the edge that registers the write cycle, using a per-byte mask. Reads come out through either one or two registers, chosen by a static mode input. The data output has a drive flag, which acts like a tristate enable and which an asynchronous output enable can force off.

Top module: `burst_sram_core`

## Requirements
- R1: While reset is asserted, and after it is released, `rdata_en_o` is low, `rdata_o` is zero and no burst is open.
- R2: An edge with `proc_strobe_ni` low, `ce1_ni` low and the secondary enables true starts a burst at `addr_i`. That cycle is a read even when the write inputs request a write.
- R3: While `ce1_ni` is high, `proc_strobe_ni` has no effect. With `ctrl_strobe_ni` also high the edge acts as a continue or suspend cycle. An edge with `ctrl_strobe_ni` low and `ce1_ni` high is a deselect.
- R4: An edge with `ctrl_strobe_ni` low, `proc_strobe_ni` high and all enables true starts a burst at `addr_i`. It is a write when the write decode is true and a read otherwise.
- R5: The secondary enables are true when `ce2_i` is high and `ce3_ni` is low. They are consulted only on strobe edges, where a false value gives a deselect. On edges with neither strobe low they have no effect.
- R6: With both strobes high and a burst open, `advance_ni` low moves to the next address and `advance_ni` high holds the current one. With the default interleaved order, the accessed word is the start address with its bits [1:0] XORed by a 2-bit count. The count is 0 at burst start, and it wraps to the start address on the fifth access. With no burst open (after reset or a deselect), such an edge accesses nothing.
- R7: The write decode is true when `global_we_ni` is low, which writes every byte. It is also true when `byte_we_ni` is low and at least one bit of `byte_sel_ni` is low, which writes only the bytes whose bit is low. Bit j selects bits [8j+7:8j]. In every other case the cycle is a read.
- R8: A read drives all byte lanes whatever `byte_sel_ni` holds. A write's output slot has `rdata_en_o` low. `rdata_o` is zero whenever `rdata_en_o` is low.
- R9: With `flow_mode_ni` low (flow-through), the read data appears in the cycle after the edge that registers the access. With `flow_mode_ni` high (pipelined), it appears one cycle later.
- R10: `oe_ni` high forces `rdata_en_o` low at once, without waiting for a clock. A read taken with `oe_ni` high still advances the burst count.
- R11: The first output slot that belongs to a deselect cycle has `rdata_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| proc_strobe_ni | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| advance_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Secondary chip enable, active low |
| byte_we_ni | input | 1 | Byte-write enable, active low |
| byte_sel_ni | input | NUM_BYTES | Per-byte write strobes, active low |
| global_we_ni | input | 1 | Write all bytes, active low |
| flow_mode_ni | input | 1 | Static mode: low for flow-through, high for pipelined |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | NUM_BYTES*BYTE_W | Write data |
| rdata_o | output | NUM_BYTES*BYTE_W | Read data, zero when not driven |
| rdata_en_o | output | 1 | Output drive flag |

## Verification
Several properties are checked on every cycle:
- A processor-strobe cycle never writes a lane.
- No lane is written when both write inputs are high.
- The output slot of a write or deselect has the drive flag low in either mode.
- A high output enable always suppresses the drive flag.
- A suspend cycle keeps the registered address.
- A flow-through read with output enable low is driven in the next cycle.

Only the bench scenarios can show which data comes back. That covers the interleaved visiting order and its wrap, byte-masked merging, a dummy read moving the counter, and the strobe and enable combinations that are ignored. These scenarios are run in both read modes against a reference array.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_LOAD = 2'd1,
    CYC_STEP = 2'd2,
    CYC_HOLD = 2'd3
  } cyc_e;
endpackage

// File: rtl/burst_sram_decode.sv
`timescale 1ns/1ps
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 proc_strobe_ni,
  input  logic                 ctrl_strobe_ni,
  input  logic                 advance_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 byte_we_ni,
  input  logic [NUM_BYTES-1:0] byte_sel_ni,
  input  logic                 global_we_ni,
  input  logic                 burst_open_i,
  output cyc_e                 cyc_o,
  output logic                 write_o,
  output logic                 close_o,
  output logic [NUM_BYTES-1:0] lane_we_o
);
  logic                 proc_hit, ctrl_hit, sec_ok, wr_dec;
  logic [NUM_BYTES-1:0] wr_mask;

  always_comb begin
    proc_hit = !proc_strobe_ni && !ce1_ni;
    ctrl_hit = !ctrl_strobe_ni;
    sec_ok   = ce2_i && !ce3_ni;
    if (!global_we_ni)    wr_mask = '1;
    else if (!byte_we_ni) wr_mask = ~byte_sel_ni;
    else                  wr_mask = '0;
    wr_dec  = |wr_mask;
    cyc_o   = CYC_IDLE;
    write_o = 1'b0;
    close_o = 1'b0;
    if (proc_hit) begin
      // processor strobe always reads
      if (sec_ok) cyc_o = CYC_LOAD;
      else        close_o = 1'b1;
    end else if (ctrl_hit) begin
      if (ce1_ni || !sec_ok) close_o = 1'b1;
      else begin
        cyc_o   = CYC_LOAD;
        write_o = wr_dec;
      end
    end else if (burst_open_i) begin
      cyc_o   = advance_ni ? CYC_HOLD : CYC_STEP;
      write_o = wr_dec;
    end
    lane_we_o = write_o ? wr_mask : '0;
  end
endmodule

// File: rtl/burst_sram_counter.sv
`timescale 1ns/1ps
module burst_sram_counter
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter bit LINEAR_ORDER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic              close_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              open_o
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q, base_n, cur_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, low_bits;
  logic              open_q;

  always_comb begin
    base_n = (cyc_i == CYC_LOAD) ? addr_i : base_q;
    case (cyc_i)
      CYC_LOAD: cnt_n = '0;
      CYC_STEP: cnt_n = cnt_q + CNT_W'(1);
      default:  cnt_n = cnt_q;
    endcase
  end

  if (LINEAR_ORDER) begin : g_linear
    assign low_bits = base_n[CNT_W-1:0] + cnt_n;
  end else begin : g_interleave
    assign low_bits = base_n[CNT_W-1:0] ^ cnt_n;
  end

  assign acc_addr_o = {base_n[ADDR_W-1:CNT_W], low_bits};
  assign cur_addr_o = cur_q;
  assign open_o     = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      cur_q  <= '0;
      open_q <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      if (cyc_i != CYC_IDLE) cur_q <= acc_addr_o;
      if (cyc_i == CYC_LOAD) open_q <= 1'b1;
      else if (close_i)      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_sram_lane.sv
`timescale 1ns/1ps
module burst_sram_lane #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [BYTE_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/burst_sram_outpath.sv
`timescale 1ns/1ps
module burst_sram_outpath #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flow_mode_ni,
  input  logic              slot_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_en_o
);
  logic              en1_q, en2_q, en_sel;
  logic [DATA_W-1:0] d2_q, d_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en1_q <= 1'b0;
      en2_q <= 1'b0;
      d2_q  <= '0;
    end else begin
      en1_q <= slot_en_i;
      en2_q <= en1_q;
      d2_q  <= rd_data_i;
    end
  end

  always_comb begin
    en_sel     = flow_mode_ni ? en2_q : en1_q;
    d_sel      = flow_mode_ni ? d2_q : rd_data_i;
    rdata_en_o = en_sel && !oe_ni;
    rdata_o    = rdata_en_o ? d_sel : '0;
  end
endmodule

// File: rtl/burst_sram_core.sv
`timescale 1ns/1ps
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NUM_BYTES    = 4,
  parameter int BYTE_W       = 8,
  parameter bit LINEAR_ORDER = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        proc_strobe_ni,
  input  logic                        ctrl_strobe_ni,
  input  logic                        advance_ni,
  input  logic                        ce1_ni,
  input  logic                        ce2_i,
  input  logic                        ce3_ni,
  input  logic                        byte_we_ni,
  input  logic [NUM_BYTES-1:0]        byte_sel_ni,
  input  logic                        global_we_ni,
  input  logic                        flow_mode_ni,
  input  logic                        oe_ni,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o,
  output logic                        rdata_en_o
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  cyc_e                 cyc;
  logic                 wr_cyc, close_cyc, burst_open, slot_en;
  logic [NUM_BYTES-1:0] lane_we;
  logic [ADDR_W-1:0]    acc_addr, cur_addr;
  logic [DATA_W-1:0]    rd_word;

  burst_sram_decode #(.NUM_BYTES(NUM_BYTES)) u_decode (
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .advance_ni     (advance_ni),
    .ce1_ni         (ce1_ni),
    .ce2_i          (ce2_i),
    .ce3_ni         (ce3_ni),
    .byte_we_ni     (byte_we_ni),
    .byte_sel_ni    (byte_sel_ni),
    .global_we_ni   (global_we_ni),
    .burst_open_i   (burst_open),
    .cyc_o          (cyc),
    .write_o        (wr_cyc),
    .close_o        (close_cyc),
    .lane_we_o      (lane_we)
  );

  burst_sram_counter #(.ADDR_W(ADDR_W), .LINEAR_ORDER(LINEAR_ORDER)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc),
    .close_i    (close_cyc),
    .addr_i     (addr_i),
    .acc_addr_o (acc_addr),
    .cur_addr_o (cur_addr),
    .open_o     (burst_open)
  );

  assign slot_en = (cyc != CYC_IDLE) && !wr_cyc;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    burst_sram_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
      .clk_i   (clk_i),
      .we_i    (lane_we[g]),
      .re_i    (slot_en),
      .addr_i  (acc_addr),
      .wdata_i (wdata_i[g*BYTE_W +: BYTE_W]),
      .rdata_o (rd_word[g*BYTE_W +: BYTE_W])
    );
  end

  burst_sram_outpath #(.DATA_W(DATA_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flow_mode_ni (flow_mode_ni),
    .slot_en_i    (slot_en),
    .rd_data_i    (rd_word),
    .oe_ni        (oe_ni),
    .rdata_o      (rdata_o),
    .rdata_en_o   (rdata_en_o)
  );
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 proc_strobe_ni,
  input logic                 ce1_ni,
  input logic                 global_we_ni,
  input logic                 byte_we_ni,
  input logic                 flow_mode_ni,
  input logic                 oe_ni,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 rdata_en_o,
  input cyc_e                 cyc,
  input logic                 close_cyc,
  input logic                 slot_en,
  input logic [NUM_BYTES-1:0] lane_we,
  input logic [ADDR_W-1:0]    cur_addr
);
  // R2
  proc_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && !ce1_ni) |-> (lane_we == '0));
  // R7
  no_wr_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (global_we_ni && byte_we_ni) |-> (lane_we == '0));
  // R8
  wr_slot_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we && !flow_mode_ni) |=> !rdata_en_o);
  // R8
  wr_slot_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we && flow_mode_ni) |=> ##1 !rdata_en_o);
  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_en_o |-> (rdata_o == '0));
  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_en_o);
  // R11
  desel_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_cyc && !flow_mode_ni) |=> !rdata_en_o);
  // R11
  desel_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_cyc && flow_mode_ni) |=> ##1 !rdata_en_o);
  // R6
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_HOLD) |=> $stable(cur_addr));
  // R9
  flow_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en && !flow_mode_ni) |=> (oe_ni || rdata_en_o));
endmodule

bind burst_sram_core burst_sram_chk #(
  .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .DATA_W(NUM_BYTES*BYTE_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .proc_strobe_ni (proc_strobe_ni),
  .ce1_ni         (ce1_ni),
  .global_we_ni   (global_we_ni),
  .byte_we_ni     (byte_we_ni),
  .flow_mode_ni   (flow_mode_ni),
  .oe_ni          (oe_ni),
  .rdata_o        (rdata_o),
  .rdata_en_o     (rdata_en_o),
  .cyc            (cyc),
  .close_cyc      (close_cyc),
  .slot_en        (slot_en),
  .lane_we        (lane_we),
  .cur_addr       (cur_addr)
);

// File: tb/sim_burst_sram_core.sv
`timescale 1ns/1ps
module sim_burst_sram_core;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, adv_n, ce1_n, ce2, ce3_n, bwe_n, gwe_n, flow_n, oe_n;
  logic [NB-1:0] sel_n;
  logic [DW-1:0] wd;
  logic [DW-1:0] rdata;
  logic          rdata_en;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] ref_mem [256];
  logic          m_open;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          e1_en, e2_en;
  logic [DW-1:0] e1_d, e2_d;

  always #2.5 clk = ~clk;

  burst_sram_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .proc_strobe_ni(proc_n), .ctrl_strobe_ni(ctrl_n), .advance_ni(adv_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .byte_we_ni(bwe_n), .byte_sel_ni(sel_n), .global_we_ni(gwe_n),
    .flow_mode_ni(flow_n), .oe_ni(oe_n), .wdata_i(wd),
    .rdata_o(rdata), .rdata_en_o(rdata_en)
  );

  task automatic set_idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    bwe_n = 1; sel_n = '1; gwe_n = 1; oe_n = 0; addr = '0; wd = '0;
  endtask

  task automatic model_reset();
    m_open = 0; m_base = '0; m_cnt = '0;
    e1_en = 0; e2_en = 0; e1_d = '0; e2_d = '0;
  endtask

  task automatic model_edge();
    logic          sec, wr, rd;
    logic [NB-1:0] mask;
    logic [AW-1:0] a;
    int            op; // 0 none, 1 start, 2 next, 3 hold, 4 deselect
    sec  = ce2 && !ce3_n;
    mask = !gwe_n ? '1 : (!bwe_n ? ~sel_n : '0);
    op = 0; wr = 0;
    if (!proc_n && !ce1_n) op = sec ? 1 : 4;
    else if (!ctrl_n) begin
      op = (ce1_n || !sec) ? 4 : 1;
      wr = (op == 1) && (mask != 0);
    end else if (m_open) begin
      op = adv_n ? 3 : 2;
      wr = (mask != 0);
    end
    a = '0;
    if (op == 1) begin m_base = addr; m_cnt = 0; m_open = 1; end
    if (op == 4) m_open = 0;
    if (op == 2) m_cnt = m_cnt + 2'd1;
    if (op >= 1 && op <= 3) a = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
    if (wr) for (int j = 0; j < NB; j++)
      if (mask[j]) ref_mem[a][j*8 +: 8] = wd[j*8 +: 8];
    rd = (op >= 1 && op <= 3) && !wr;
    e2_en = e1_en; e2_d = e1_d;
    e1_en = rd;    e1_d = rd ? ref_mem[a] : e1_d;
  endtask

  task automatic compare(input string tag);
    logic          xen;
    logic [DW-1:0] xd;
    xen = (flow_n ? e2_en : e1_en) && !oe_n;
    xd  = xen ? (flow_n ? e2_d : e1_d) : '0;
    checks++;
    if (rdata_en !== xen || rdata !== xd) begin
      errors++;
      $display("FAIL %s mode=%0b actual en=%0b data=%h expected en=%0b data=%h",
               tag, flow_n, rdata_en, rdata, xen, xd);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic do_ctrl(input logic [AW-1:0] a, input logic g, input logic b,
                         input logic [NB-1:0] s, input logic [DW-1:0] d, input string tag);
    set_idle(); ctrl_n = 0; addr = a; gwe_n = g; bwe_n = b; sel_n = s; wd = d;
    step(tag);
  endtask

  task automatic do_proc(input logic [AW-1:0] a, input string tag);
    set_idle(); proc_n = 0; addr = a; gwe_n = 0; wd = 32'hDEAD_BEEF;
    step(tag);
  endtask

  task automatic do_cont(input logic adv, input logic g, input logic [DW-1:0] d,
                         input string tag);
    set_idle(); adv_n = adv; gwe_n = g; wd = d;
    step(tag);
  endtask

  task automatic do_desel(input string tag);
    set_idle(); ctrl_n = 0; ce1_n = 1;
    step(tag);
  endtask

  task automatic scenario();
    do_desel("R11");
    do_ctrl(8'h10, 0, 1, '1, 32'hA1B2_C3D4, "R4");
    do_ctrl(8'h22, 0, 1, '1, 32'h0000_2222, "R4");
    do_cont(0, 0, 32'h0000_2323, "R6");
    do_cont(0, 0, 32'h0000_2020, "R6");
    do_cont(0, 0, 32'h0000_2121, "R6");
    // R2: read despite global write low, then interleaved burst and wrap
    do_proc(8'h22, "R2");
    do_cont(0, 1, '0, "R6");
    do_cont(0, 1, '0, "R6");
    do_cont(0, 1, '0, "R6");
    do_cont(0, 1, '0, "R6");
    do_cont(1, 1, '0, "R6");
    do_proc(8'h10, "R9");
    // R7 byte lanes 1 and 3 selected by low bits 1 and 3
    do_ctrl(8'h10, 1, 0, 4'b0101, 32'h1122_3344, "R7");
    do_ctrl(8'h10, 1, 0, 4'b1111, 32'hFFFF_FFFF, "R7");
    do_ctrl(8'h10, 1, 1, 4'b0000, 32'hFFFF_FFFF, "R7");
    do_desel("R11");
    do_desel("R11");
    // R3: processor strobe ignored while ce1 high
    do_ctrl(8'h20, 1, 1, '1, '0, "R4");
    set_idle(); proc_n = 0; ce1_n = 1; adv_n = 0; step("R3");
    do_cont(1, 1, '0, "R3");
    do_desel("R3");
    // R5
    set_idle(); ctrl_n = 0; addr = 8'h21; ce2 = 0; step("R5");
    set_idle(); ctrl_n = 0; addr = 8'h21; ce3_n = 1; step("R5");
    do_cont(0, 1, '0, "R6");
    do_cont(1, 1, '0, "R6");
    do_ctrl(8'h20, 1, 1, '1, '0, "R5");
    set_idle(); adv_n = 0; ce2 = 0; ce3_n = 1; step("R5");
    // R10 dummy read advances
    set_idle(); adv_n = 0; oe_n = 1; step("R10");
    set_idle(); oe_n = 1; step("R10");
    do_cont(1, 1, '0, "R10");
    do_cont(1, 1, '0, "R10");
    oe_n = 1; #1; compare("R10");
    oe_n = 0; #1; compare("R10");
    do_desel("R11");
    do_desel("R11");
    do_desel("R11");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_idle();
    model_reset();
    flow_n = 1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk);
    rst_ni = 1;
    do_cont(0, 1, '0, "R1");
    scenario();
    // flow-through pass
    @(negedge clk);
    rst_ni = 0;
    model_reset();
    flow_n = 0;
    #1;
    compare("R1");
    @(negedge clk);
    rst_ni = 1;
    scenario();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule